// File: doc/BRIEF.md
# Bank-Set Activation Spacing Scheduler

This block sits in the request path of a memory controller. It decides when row-activation commands may go out to a DRAM organised as two bank sets. The two command kinds are a plain activate and a refresh-activate. Each request carries a command kind and a bank-set index. The scheduler accepts it with a valid/ready handshake. One clock later it emits it as a packet together with a one-bit delay field. The command takes effect inside the DRAM at packet time plus delay.

Two programmable spacings are enforced on those effective times. The first is a same-set gap, which applies between activations to the same bank set. The second is a cross-set gap, which applies between activations to different bank sets and may be as small as zero. A cross-set gap larger than the same-set gap is treated as equal to it. When the cross-set gap is zero, the scheduler can raise the delay of the packet in flight. This happens when the request then waiting at its input targets the other set and is taken in that cycle. Both activations then land on the same internal edge.

Top module: `act_spacing_sched`

## Requirements
- R1: After synchronous reset no packet is emitted. The first request presented afterwards is accepted in the first cycle it is valid.
- R2: A handshake (req_valid and req_ready high at a clock edge) produces exactly one packet in the next cycle, with the same kind (0 = activate, 1 = refresh-activate) and set. No packet appears in any other cycle.
- R3: Two packets to the same set have effective times (packet cycle plus pkt_delay) at least cfg_same_gap apart.
- R4: Two packets to different sets have effective times at least min(cfg_cross_gap, cfg_same_gap) apart.
- R5: A held request is accepted in the earliest cycle whose effective time (acceptance cycle plus one) meets both the same-set and the cross-set spacing.
- R6: pkt_delay is 1 exactly when all of the following hold: a packet is out, the effective cross-set gap is 0, and the request at the input targets the other set and is accepted in that cycle. Otherwise pkt_delay is 0.
- R7: A cfg_cross_gap above cfg_same_gap schedules exactly as if it equalled cfg_same_gap.
- R8: Spacing counters saturate. After an idle stretch longer than the counter range, a request is accepted at once.
- R9: Activate and refresh-activate requests obey identical spacing rules.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_kind | input | 1 | 0 = activate, 1 = refresh-activate |
| req_set | input | 1 | Target bank set |
| cfg_same_gap | input | 4 | Minimum cycles between activations to one set |
| cfg_cross_gap | input | 4 | Minimum cycles between activations to different sets |
| req_ready | output | 1 | Request accepted this cycle when valid |
| pkt_valid | output | 1 | Packet emitted this cycle |
| pkt_kind | output | 1 | Kind of emitted packet |
| pkt_set | output | 1 | Bank set of emitted packet |
| pkt_delay | output | 1 | Internal issue delay of emitted packet, 0 or 1 cycle |

## Verification
The hardest case to reach is the delayed packet. Three things must line up in the same cycle: a packet must be in the output stage, the effective cross-set gap must be zero, and a request for the other set must already be waiting with its own set's spacing clear. The bench sweeps every pairing of several same-set and cross-set gaps, clamped values included. In each configuration it sends back-to-back requests with pseudo-random sets, kinds and mostly zero idle gaps, so that alternating-set pairs arrive right behind a packet. A model built on effective times predicts the ready and delay value in every cycle.

// File: rtl/act_sched_pkg.sv
package act_sched_pkg;

    localparam int NUM_SETS = 2;
    localparam int SET_W    = $clog2(NUM_SETS);
    localparam int GAP_W    = 4;
    localparam logic [GAP_W-1:0] GAP_MAX = {GAP_W{1'b1}};

    typedef logic [GAP_W-1:0] gap_t;
    typedef logic [SET_W-1:0] set_t;

    typedef enum logic {
        CMD_ACT  = 1'b0,
        CMD_REFA = 1'b1
    } act_kind_e;

    typedef struct packed {
        act_kind_e kind;
        set_t      set;
    } act_req_t;

    // saturating increment of a spacing counter
    function automatic gap_t gap_sat_inc(gap_t v);
        return (v == GAP_MAX) ? v : v + gap_t'(1);
    endfunction

    function automatic gap_t gap_min(gap_t a, gap_t b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/act_gap_tracker.sv
// Counters hold the distance, in cycles, between the effective time of the
// latest activation and the effective time a request accepted now would get.
module act_gap_tracker
    import act_sched_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    pkt_valid,
    input  set_t                    pkt_set,
    input  logic                    pkt_delay,
    output gap_t [NUM_SETS-1:0]     cnt_set,
    output gap_t                    cnt_any
);

    gap_t lead;
    gap_t cnt_q [NUM_SETS];
    gap_t any_q;

    // distance of the packet in flight from the next candidate slot
    assign lead = pkt_delay ? '0 : gap_t'(1);

    generate
        for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
            always_ff @(posedge clk) begin
                if (rst)
                    cnt_q[s] <= GAP_MAX;
                else if (pkt_valid && pkt_set == set_t'(s))
                    cnt_q[s] <= gap_sat_inc(lead);
                else
                    cnt_q[s] <= gap_sat_inc(cnt_q[s]);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            any_q <= GAP_MAX;
        else if (pkt_valid)
            any_q <= gap_sat_inc(lead);
        else
            any_q <= gap_sat_inc(any_q);
    end

    always_comb begin
        for (int s = 0; s < NUM_SETS; s++)
            cnt_set[s] = cnt_q[s];
    end
    assign cnt_any = any_q;

    // R8: an idle counter at its ceiling stays there
    a_r8_saturate: assert property (@(posedge clk) disable iff (rst)
        (!$past(pkt_valid) && $past(any_q) == GAP_MAX) |-> any_q == GAP_MAX);

endmodule

// File: rtl/act_issue_decider.sv
module act_issue_decider
    import act_sched_pkg::*;
(
    input  logic                    req_valid,
    input  set_t                    req_set,
    input  logic                    pkt_valid,
    input  set_t                    pkt_set,
    input  gap_t [NUM_SETS-1:0]     cnt_set,
    input  gap_t                    cnt_any,
    input  gap_t                    same_gap,
    input  gap_t                    cross_gap,
    output logic                    req_ready,
    output logic                    pkt_delay
);

    gap_t cross_eff;
    gap_t own_dist;
    gap_t any_dist;
    logic own_clear;
    logic pull;

    // R7: cross-set gap never exceeds the same-set gap
    assign cross_eff = gap_min(cross_gap, same_gap);
    assign own_clear = cnt_set[req_set] >= same_gap;

    // delay the packet in flight so the waiting other-set request lands with it
    assign pull = pkt_valid && req_valid && (req_set != pkt_set)
                  && (cross_eff == '0) && own_clear;

    always_comb begin
        if (pkt_valid && pkt_set == req_set)
            own_dist = gap_t'(1);
        else
            own_dist = cnt_set[req_set];
        if (pkt_valid)
            any_dist = pull ? '0 : gap_t'(1);
        else
            any_dist = cnt_any;
    end

    assign req_ready = (own_dist >= same_gap) && (any_dist >= cross_eff);
    assign pkt_delay = pull;

endmodule

// File: rtl/act_packet_reg.sv
module act_packet_reg
    import act_sched_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  act_req_t din,
    output logic     pkt_valid,
    output act_req_t pkt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            pkt_valid <= 1'b0;
            pkt       <= '{kind: CMD_ACT, set: '0};
        end else begin
            pkt_valid <= load;
            if (load)
                pkt <= din;
        end
    end

    // R1: nothing leaves in the cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !pkt_valid);

endmodule

// File: rtl/act_spacing_sched.sv
module act_spacing_sched
    import act_sched_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_kind,
    input  logic [SET_W-1:0] req_set,
    input  logic [GAP_W-1:0] cfg_same_gap,
    input  logic [GAP_W-1:0] cfg_cross_gap,
    output logic             req_ready,
    output logic             pkt_valid,
    output logic             pkt_kind,
    output logic [SET_W-1:0] pkt_set,
    output logic             pkt_delay
);

    act_req_t            in_req;
    act_req_t            out_req;
    logic                fire;
    gap_t [NUM_SETS-1:0] cnt_set;
    gap_t                cnt_any;

    assign in_req = '{kind: act_kind_e'(req_kind), set: req_set};
    assign fire   = req_valid && req_ready;

    act_gap_tracker u_tracker (
        .clk       (clk),
        .rst       (rst),
        .pkt_valid (pkt_valid),
        .pkt_set   (out_req.set),
        .pkt_delay (pkt_delay),
        .cnt_set   (cnt_set),
        .cnt_any   (cnt_any)
    );

    act_issue_decider u_decider (
        .req_valid (req_valid),
        .req_set   (req_set),
        .pkt_valid (pkt_valid),
        .pkt_set   (out_req.set),
        .cnt_set   (cnt_set),
        .cnt_any   (cnt_any),
        .same_gap  (cfg_same_gap),
        .cross_gap (cfg_cross_gap),
        .req_ready (req_ready),
        .pkt_delay (pkt_delay)
    );

    act_packet_reg u_pkt (
        .clk       (clk),
        .rst       (rst),
        .load      (fire),
        .din       (in_req),
        .pkt_valid (pkt_valid),
        .pkt       (out_req)
    );

    assign pkt_kind = out_req.kind;
    assign pkt_set  = out_req.set;

    // R2: a handshake yields the matching packet one cycle later
    a_r2_accept_emits: assert property (@(posedge clk) disable iff (rst)
        fire |=> (pkt_valid && pkt_set == $past(req_set) && pkt_kind == $past(req_kind)));

    // R2: no packet without a handshake
    a_r2_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !fire |=> !pkt_valid);

    // R6: a delayed packet is always followed by its other-set partner
    a_r6_delay_partner: assert property (@(posedge clk) disable iff (rst)
        pkt_delay |=> (pkt_valid && pkt_set != $past(pkt_set)));

    // R3: same-set packets on consecutive cycles only with a tiny same-set gap
    a_r3_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (pkt_valid && $past(pkt_valid) && pkt_set == $past(pkt_set) && !$past(pkt_delay))
        |-> $past(cfg_same_gap) <= gap_t'(1));

endmodule

// File: tb/act_spacing_sched_tb.sv
module act_spacing_sched_tb;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req_valid = 1'b0;
    logic       req_kind = 1'b0;
    logic [0:0] req_set = '0;
    logic [3:0] cfg_same_gap = 4'd4;
    logic [3:0] cfg_cross_gap = 4'd4;
    logic       req_ready;
    logic       pkt_valid;
    logic       pkt_kind;
    logic [0:0] pkt_set;
    logic       pkt_delay;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    act_spacing_sched u_dut (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_kind      (req_kind),
        .req_set       (req_set),
        .cfg_same_gap  (cfg_same_gap),
        .cfg_cross_gap (cfg_cross_gap),
        .req_ready     (req_ready),
        .pkt_valid     (pkt_valid),
        .pkt_kind      (pkt_kind),
        .pkt_set       (pkt_set),
        .pkt_delay     (pkt_delay)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model on effective issue times
    int cyc = 0;
    int last_eff [2];
    bit acc_prev = 0;
    int kind_prev = 0;
    int set_prev = 0;

    always @(negedge clk) begin
        int same, ce, eff, other, rs, cand, exp_d, gap;
        bit exp_r;
        cyc++;
        if (rst) begin
            last_eff[0] = -1000;
            last_eff[1] = -1000;
            acc_prev = 0;
        end else begin
            same = int'(cfg_same_gap);
            ce = (cfg_cross_gap < cfg_same_gap) ? int'(cfg_cross_gap) : same;
            chk(pkt_valid == acc_prev, "R2 packet presence", pkt_valid, acc_prev);
            if (acc_prev && pkt_valid) begin
                chk(int'(pkt_kind) == kind_prev, "R2 kind", pkt_kind, kind_prev);
                chk(int'(pkt_set) == set_prev, "R2 set", pkt_set, set_prev);
            end
            rs = int'(req_set);
            exp_d = 0;
            if (pkt_valid && req_valid && req_set != pkt_set && ce == 0
                && (cyc + 1 - last_eff[rs] >= same))
                exp_d = 1;
            chk(int'(pkt_delay) == exp_d, "R6 delay", pkt_delay, exp_d);
            if (pkt_valid) begin
                eff = cyc + int'(pkt_delay);
                other = 1 - int'(pkt_set);
                chk(eff - last_eff[pkt_set] >= same, "R3 same-set spacing",
                    eff - last_eff[pkt_set], same);
                gap = eff - last_eff[other];
                if (gap < 0) gap = -gap;
                chk(gap >= ce, (cfg_cross_gap > cfg_same_gap) ? "R4 R7 cross spacing"
                                                                : "R4 cross spacing", gap, ce);
                last_eff[pkt_set] = eff;
            end
            if (req_valid) begin
                cand = cyc + 1;
                exp_r = (cand - last_eff[rs] >= same) && (cand - last_eff[1 - rs] >= ce);
                chk(req_ready == exp_r,
                    req_kind ? "R5 R9 ready for refresh" : "R5 ready for activate",
                    req_ready, exp_r);
            end
            acc_prev = req_valid && req_ready;
            kind_prev = int'(req_kind);
            set_prev = rs;
        end
    end

    task automatic send(input bit kind, input bit set);
        bit got;
        req_valid = 1'b1;
        req_kind = kind;
        req_set = set;
        got = 1'b0;
        while (!got) begin
            @(negedge clk);
            got = req_ready;
            @(posedge clk);
            #1;
        end
        req_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        req_valid = 1'b0;
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        req_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        int sames [4] = '{4, 2, 1, 3};
        int crosses [5] = '{0, 1, 2, 4, 7};
        do_reset();

        // R1: first request goes at once, no packet yet
        req_valid = 1'b1;
        req_kind = 1'b0;
        req_set = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 first request ready", req_ready, 1);
        chk(pkt_valid == 1'b0, "R1 no packet after reset", pkt_valid, 0);
        @(posedge clk);
        #1;
        req_valid = 1'b0;

        // R8: idle longer than counter range, then immediate acceptance
        send(1'b1, 1'b1);
        idle(40);
        req_valid = 1'b1;
        req_set = 1'b1;
        req_kind = 1'b0;
        @(negedge clk);
        chk(req_ready == 1'b1, "R8 ready after long idle", req_ready, 1);
        @(posedge clk);
        #1;
        req_valid = 1'b0;

        for (int a = 0; a < 4; a++) begin
            for (int b = 0; b < 5; b++) begin
                cfg_same_gap = 4'(sames[a]);
                cfg_cross_gap = 4'(crosses[b]);
                do_reset();
                for (int k = 0; k < 30; k++) begin
                    lfsr = step(lfsr);
                    if (lfsr[7:5] == 3'd0) idle(int'(lfsr[2:1]) + 1);
                    send(lfsr[4], lfsr[0] ^ lfsr[9]);
                end
                // strictly alternating pairs stress the delay path
                for (int k = 0; k < 8; k++)
                    send(k[1], k[0]);
                idle(3);
            end
        end

        idle(2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule